// File: doc/BRIEF.md
# Windowed Peak Magnitude Monitor

This block watches a stream of signed converter samples and reports the largest absolute value seen in each measurement window. The window length is a count of accepted samples, taken from a 24-bit period input. A down-counter times the window and reloads itself with no gap between windows. When a window closes, the held peak is copied into a 20-bit result register and a one-cycle update strobe is raised.

The sample that closes a window is not lost. It becomes the first sample of the next window, so the running peak restarts from that sample's magnitude rather than from zero. A gain-control loop or a software poller can use the result register directly. It can either wait for the strobe or read the register at any time, since the register holds its value between updates.

Top module: `peak_window_monitor`

## Requirements
- R1: The magnitude of a sample is its absolute value as a 14-bit two's-complement number; the code -8192 gives 8191.
- R2: The first accepted sample after enable (en_i and valid_i both high) seeds the peak and opens a window of P samples, where P is the effective period. The P-th accepted sample after the seed closes the window. On the clock edge that accepts that closing sample, result_o takes the maximum magnitude of the P samples from the seed up to the one just before it.
- R3: Windows follow one another with no gap. The closing sample is the first sample of the next window, so every later result is the maximum magnitude of the next group of P consecutive accepted samples.
- R4: Cycles with valid_i low neither advance the window nor affect the peak, whatever value sample_i carries.
- R5: The effective period is period_i, except that any value below 128 (including 0) is treated as 128.
- R6: update_o is high for exactly the one cycle that follows each write of result_o. result_o does not change in any other cycle.
- R7: While rst_ni is low, result_o is 0 and update_o is 0.
- R8: While en_i is low, no result is produced and result_o keeps its value. After en_i returns high, the next accepted sample seeds a fresh window as described in R2.
- R9: period_i is sampled when a window opens, either at the seed or at the closing sample. A change to period_i in the middle of a window takes effect from the next window.
- R10: result_o is the 13-bit peak zero-extended to 20 bits, so bits 19:13 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Measurement enable; low stops and re-arms the window |
| valid_i | input | 1 | Qualifies sample_i for this cycle |
| sample_i | input | 14 | Signed two's-complement sample |
| period_i | input | 24 | Window length in accepted samples |
| result_o | output | 20 | Peak magnitude of the last completed window |
| update_o | output | 1 | One-cycle pulse after result_o is written |

## Verification
The hardest situation to reach from the ports is a window boundary that coincides with other events: a gap in valid_i, a change of period_i in mid-window, or the most negative code arriving as the sample that closes or seeds a window. The stimulus feeds every one of the 16384 sample codes, in a scrambled but deterministic order, through back-to-back windows of 128 samples. Boundaries therefore land on many different codes. Further phases repeat the process with sparse valid_i, with period_i changed in mid-window, with a disable in mid-window, and with a large decoy value driven on invalid cycles. A bench model of windows counted in samples predicts every cycle.

// File: rtl/pkm_pkg.sv
package pkm_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} win_state_e;
endpackage

// File: rtl/pkm_abs.sv
module pkm_abs #(
  parameter int SAMPLE_W = 14,
  localparam int MAG_W   = SAMPLE_W - 1
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [MAG_W-1:0]    mag_o
);
  logic [SAMPLE_W-1:0] neg_v;
  logic                is_min;

  assign neg_v  = ~sample_i + 1'b1;
  assign is_min = sample_i[SAMPLE_W-1] && (sample_i[SAMPLE_W-2:0] == '0);

  always_comb begin
    if (is_min)                     mag_o = '1;  // saturate most negative code
    else if (sample_i[SAMPLE_W-1])  mag_o = neg_v[MAG_W-1:0];
    else                            mag_o = sample_i[MAG_W-1:0];
  end
endmodule

// File: rtl/pkm_timer.sv
module pkm_timer
  import pkm_pkg::*;
#(
  parameter int PERIOD_W   = 24,
  parameter int MIN_PERIOD = 128
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                valid_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                seed_o,
  output logic                fire_o
);
  win_state_e          state_q;
  logic [PERIOD_W-1:0] cnt_q;
  logic [PERIOD_W-1:0] eff_period;
  logic                take;

  assign eff_period = (period_i < PERIOD_W'(MIN_PERIOD)) ? PERIOD_W'(MIN_PERIOD) : period_i;
  assign take       = en_i && valid_i;
  assign seed_o     = take && (state_q == ST_IDLE);
  assign fire_o     = take && (state_q == ST_RUN) && (cnt_q == PERIOD_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= PERIOD_W'(MIN_PERIOD);
    end else if (!en_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= eff_period;
    end else if (state_q == ST_IDLE) begin
      cnt_q <= eff_period;
      if (valid_i) state_q <= ST_RUN;
    end else if (valid_i) begin
      cnt_q <= fire_o ? eff_period : cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/pkm_peak.sv
module pkm_peak #(
  parameter int MAG_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             restart_i,
  input  logic [MAG_W-1:0] mag_i,
  output logic [MAG_W-1:0] peak_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      peak_o <= '0;
    else if (take_i && restart_i)     peak_o <= mag_i;
    else if (take_i && mag_i > peak_o) peak_o <= mag_i;
  end
endmodule

// File: rtl/peak_window_monitor.sv
module peak_window_monitor #(
  parameter int SAMPLE_W   = 14,
  parameter int PERIOD_W   = 24,
  parameter int RESULT_W   = 20,
  parameter int MIN_PERIOD = 128
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic [RESULT_W-1:0] result_o,
  output logic                update_o
);
  localparam int PEAK_W = SAMPLE_W - 1;

  logic [PEAK_W-1:0] mag;
  logic [PEAK_W-1:0] peak;
  logic              seed;
  logic              fire;

  pkm_abs #(.SAMPLE_W(SAMPLE_W)) u_abs (
    .sample_i (sample_i),
    .mag_o    (mag)
  );

  pkm_timer #(.PERIOD_W(PERIOD_W), .MIN_PERIOD(MIN_PERIOD)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .valid_i  (valid_i),
    .period_i (period_i),
    .seed_o   (seed),
    .fire_o   (fire)
  );

  pkm_peak #(.MAG_W(PEAK_W)) u_peak (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (en_i && valid_i),
    .restart_i (seed || fire),
    .mag_i     (mag),
    .peak_o    (peak)
  );

  // closing sample belongs to the next window: publish the pre-update peak
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      update_o <= 1'b0;
    end else begin
      update_o <= fire;
      if (fire) result_o <= RESULT_W'(peak);
    end
  end
endmodule

// File: rtl/pkm_checker.sv
module pkm_checker #(
  parameter int RESULT_W   = 20,
  parameter int PEAK_W     = 13,
  parameter int MIN_PERIOD = 128
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                en_i,
  input logic                valid_i,
  input logic [RESULT_W-1:0] result_o,
  input logic                update_o
);
  localparam int GW = $clog2(MIN_PERIOD) + 2;
  logic [GW-1:0] gap_q;

  // accepted samples since the last publish, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       gap_q <= '0;
    else if (!en_i)                    gap_q <= '0;
    else if (update_o)                 gap_q <= GW'(valid_i);
    else if (valid_i && gap_q != '1)   gap_q <= gap_q + 1'b1;
  end

  p_min_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> gap_q >= GW'(MIN_PERIOD));
  p_upd_after_sample_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> $past(en_i && valid_i));
  p_upd_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |=> !update_o);
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_o |-> $stable(result_o));
  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !update_o);
  p_upper_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_o[RESULT_W-1:PEAK_W] == '0);
endmodule

bind peak_window_monitor pkm_checker #(
  .RESULT_W(RESULT_W), .PEAK_W(PEAK_W), .MIN_PERIOD(MIN_PERIOD)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .valid_i(valid_i),
  .result_o(result_o), .update_o(update_o)
);

// File: tb/peak_window_monitor_bench.sv
`timescale 1ns/1ps
module peak_window_monitor_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        valid_i = 1'b0;
  logic [13:0] sample_i = '0;
  logic [23:0] period_i = 24'd128;
  logic [19:0] result_o;
  logic        update_o;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  int exp_res = 0, pk = 0, cnt = 0;
  bit exp_upd = 0, run = 0;

  always #2.5 clk_i = ~clk_i;

  peak_window_monitor u_peak_window_monitor (.*);

  function automatic int magf(input logic [13:0] s);
    int v;
    v = $signed(s);
    if (v == -8192) return 8191;
    return (v < 0) ? -v : v;
  endfunction

  function automatic int effp(input logic [23:0] p);
    return (p < 24'd128) ? 128 : int'(p);
  endfunction

  task automatic check(input string req);
    n_vec++;
    if (update_o !== exp_upd) begin
      n_bad++;
      $display("FAIL %s update_o actual %0b expected %0b", req, update_o, exp_upd);
    end
    if (result_o !== 20'(exp_res)) begin
      n_bad++;
      $display("FAIL %s result_o actual %0d expected %0d", req, result_o, exp_res);
    end
  endtask

  // drive one cycle, advance the sample-counted window model, compare
  task automatic cyc(input bit en, input bit v, input logic [13:0] s, input string req);
    int m;
    en_i = en; valid_i = v; sample_i = s;
    @(posedge clk_i); #1;
    exp_upd = 0;
    if (en && v) begin
      m = magf(s);
      if (!run) begin run = 1; pk = m; cnt = effp(period_i); end
      else if (cnt == 1) begin exp_res = pk; exp_upd = 1; pk = m; cnt = effp(period_i); end
      else begin if (m > pk) pk = m; cnt--; end
    end else if (!en) run = 0;
    check(req);
  endtask

  initial begin
    logic [15:0] lf;
    lf = 16'hACE1;
    #12;
    n_vec++;
    if (result_o !== '0 || update_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R7 reset actual %0d/%0b expected 0/0", result_o, update_o);
    end
    @(negedge clk_i); rst_ni = 1'b1; #1;
    check("R7");

    // R1 R2 R3 R10: every code once, scrambled, windows of 128
    period_i = 24'd128;
    for (int i = 0; i < 16384; i++) cyc(1, 1, 14'(i * 37), "R1_R3_R10");

    // R8: disable mid-window with loud samples, then re-arm
    for (int i = 0; i < 40; i++) cyc(1, 1, 14'(i), "R8");
    for (int i = 0; i < 10; i++) cyc(0, 1, 14'h2000, "R8");
    for (int i = 0; i < 300; i++) cyc(1, 1, 14'(i * 3), "R8_R2");

    // R5: small periods clamp to 128
    cyc(0, 0, '0, "R5");
    period_i = 24'd5;
    for (int i = 0; i < 400; i++) cyc(1, 1, 14'(i * 101), "R5");
    cyc(0, 0, '0, "R5");
    period_i = 24'd0;
    for (int i = 0; i < 300; i++) cyc(1, 1, 14'(-i * 7), "R5");

    // R4: sparse valid, decoy on idle cycles
    cyc(0, 0, '0, "R4");
    period_i = 24'd200;
    for (int i = 0; i < 1500; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (i % 3 == 0) cyc(1, 1, {4'b0, lf[9:0]} - 14'd512, "R4");
      else            cyc(1, 0, 14'h2000, "R4");
    end

    // R9: period change in mid-window applies from next window
    cyc(0, 0, '0, "R9");
    period_i = 24'd130;
    for (int i = 0; i < 60; i++) cyc(1, 1, 14'(i), "R9");
    period_i = 24'd300;
    for (int i = 0; i < 700; i++) cyc(1, 1, 14'(i * 13), "R9");

    // R1 R6: single most-negative spike in a quiet window, result then holds
    cyc(0, 0, '0, "R1");
    period_i = 24'd128;
    for (int i = 0; i < 129; i++) cyc(1, 1, (i == 64) ? 14'h2000 : 14'd3, "R1");
    if (exp_res != 8191) begin
      n_bad++;
      $display("FAIL R1 spike model %0d expected 8191", exp_res);
    end
    for (int i = 0; i < 20; i++) cyc(0, 0, 14'h1FFF, "R6");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule